// File: doc/BRIEF.md
# MEI Line-State Action Controller

This block tracks a Modified / Exclusive / Invalid coherence state for every line of a small data cache. For each load or store request it looks at the line's current state and at the three storage attribute bits of the access: write-through, cache-inhibited and memory-coherent. From these it decides several things together. It picks the line's next state. It decides whether the cache array is read or written, and whether the processor must retry. It also chooses which bus transaction, if any, is queued, and how many beats that transaction has.

A miss that needs a fill leaves the line Invalid. Once the fill is done, a separate fill-complete input moves the line to Exclusive after a burst read, or to Modified after a read-with-intent-to-modify. A cacheable miss can also push a dirty victim out first. The caller reports this with a victim-dirty input, and the block flags the cast-out next to the main request. Reservation loads and stores take the same paths as ordinary ones, but they mark the queued bus request. All results are registered and appear one cycle after the request.

Top module: `mei_coh_ctrl`

## Requirements
- R1: After a synchronous active-high reset every line is Invalid and all outputs are 0. `rsp_state` encodes the state the request found: Invalid=0, Exclusive=1, Modified=2.
- R2: A cacheable load (`req_store`=0, `req_i`=0) to an Invalid line queues a read (`bus_kind`=1) of 4 beats. `castout_valid` equals `victim_dirty`, and the line stays Invalid.
- R3: A cacheable load that finds the line Exclusive or Modified asserts `cache_rd`, queues no bus operation (`bus_valid`=0, `bus_kind`=0, `bus_beats`=0) and leaves the state unchanged.
- R4: A cache-inhibited load behaves by state. In Invalid it queues a 1-beat read and the line stays Invalid. In Exclusive it asserts `retry` with no bus operation and the line becomes Invalid. In Modified it asserts `retry` and queues a 4-beat write-with-kill (`bus_kind`=4), and the line becomes Invalid.
- R5: A write-back store (`req_w`=0, `req_i`=0) to an Invalid line queues a read-with-intent-to-modify (`bus_kind`=2) of 4 beats. `castout_valid` equals `victim_dirty`, and the line stays Invalid. In Exclusive or Modified the store asserts `cache_wr` with no bus operation, and the line becomes Modified.
- R6: A write-through store (`req_w`=1, `req_i`=0) behaves by state. In Invalid it queues a 1-beat write-with-flush (`bus_kind`=3) and the line stays Invalid. In Exclusive it asserts `cache_wr`, queues a 1-beat write-with-flush, and the line stays Exclusive. In Modified it asserts `retry`, queues a 4-beat write-with-kill, and the line stays Modified.
- R7: A cache-inhibited store (`req_i`=1, any `req_w`) behaves by state. In Invalid it queues a 1-beat write-with-flush and the line stays Invalid. In Exclusive it asserts `retry` and the line becomes Invalid. In Modified it asserts `retry`, queues a 4-beat write-with-kill, and the line becomes Invalid.
- R8: A fill with `fill_rwitm`=0 makes its line Exclusive, and one with `fill_rwitm`=1 makes it Modified. When a request and a fill target the same line in the same cycle, the request's next state wins.
- R9: `bus_rsv` is 1 exactly when a bus operation is queued for a request with `req_rsv`=1.
- R10: `req_m` has no effect on any output or state.
- R11: Outputs appear in the cycle after the request. In a cycle with no request, `rsp_valid`, `cache_rd`, `cache_wr`, `retry`, `bus_valid`, `bus_rsv` and `castout_valid` are all 0.
- R12: `retry` is never asserted together with `cache_rd` or `cache_wr`, and `castout_valid` appears only with a 4-beat read or read-with-intent-to-modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_rsv | input | 1 | Reservation access |
| req_idx | input | IDX_W | Line index |
| req_w | input | 1 | Write-through attribute |
| req_i | input | 1 | Cache-inhibited attribute |
| req_m | input | 1 | Memory-coherent attribute |
| victim_dirty | input | 1 | A modified victim must be cast out on a miss |
| fill_valid | input | 1 | Fill complete for `fill_idx` |
| fill_idx | input | IDX_W | Line index of the finished fill |
| fill_rwitm | input | 1 | The fill was a read-with-intent-to-modify |
| rsp_valid | output | 1 | Registered result is valid |
| rsp_state | output | 2 | State the request found |
| cache_rd | output | 1 | Read the cache array |
| cache_wr | output | 1 | Write the cache array |
| retry | output | 1 | Retry the access |
| bus_valid | output | 1 | Bus request queued |
| bus_kind | output | 3 | 0 none, 1 read, 2 RWITM, 3 write-with-flush, 4 write-with-kill |
| bus_beats | output | 3 | Beat count (1 or 4, 0 when none) |
| bus_rsv | output | 1 | Bus request uses reservation encoding |
| castout_valid | output | 1 | Victim write-with-kill precedes the bus request |

## Verification
The state transitions that are hardest to reach are the ones that start from Exclusive or Modified. The only way into those states from the ports is a fill or an earlier store. The bench therefore uses a separate line for each table row. It first seeds that line with a fill of the right kind, then issues the request under test, and then probes the resulting state with a cacheable load, which never changes the state. A same-cycle fill and request on one line is driven on purpose to check the precedence rule.

// File: rtl/mei_pkg.sv
package mei_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_EXC = 2'd1,
    ST_MOD = 2'd2
  } line_state_e;

  typedef enum logic [2:0] {
    BK_NONE  = 3'd0,
    BK_READ  = 3'd1,
    BK_RWITM = 3'd2,
    BK_WFLSH = 3'd3,
    BK_WKILL = 3'd4
  } bus_kind_e;

  localparam int BURST_BEATS = 4;
  localparam int SINGLE_BEAT = 1;

  typedef struct packed {
    line_state_e nxt;
    logic        rd;
    logic        wr;
    logic        retry;
    bus_kind_e   kind;
    logic [2:0]  beats;
    logic        castout;
  } action_t;

endpackage

// File: rtl/mei_state_array.sv
module mei_state_array
  import mei_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output line_state_e      rd_state,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_state_e      wr_state,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  line_state_e      fill_state
);

  line_state_e mem [LINES];

  assign rd_state = (mem[rd_idx] == ST_EXC || mem[rd_idx] == ST_MOD) ? mem[rd_idx] : ST_INV;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LINES; k++) mem[k] <= ST_INV;
    end else begin
      if (fill_en) mem[fill_idx] <= fill_state;
      // the request is written last so that it takes precedence on a collision
      if (wr_en) mem[wr_idx] <= wr_state;
    end
  end

endmodule

// File: rtl/mei_decide.sv
module mei_decide
  import mei_pkg::*;
(
  input  line_state_e cur,
  input  logic        is_store,
  input  logic        attr_w,
  input  logic        attr_i,
  input  logic        dirty,
  output action_t     act
);

  localparam logic [2:0] B4 = 3'(BURST_BEATS);
  localparam logic [2:0] B1 = 3'(SINGLE_BEAT);

  always_comb begin
    act = '{nxt: cur, rd: 1'b0, wr: 1'b0, retry: 1'b0,
            kind: BK_NONE, beats: 3'd0, castout: 1'b0};
    if (!is_store) begin
      if (!attr_i) begin
        if (cur == ST_INV) begin
          act.kind    = BK_READ;
          act.beats   = B4;
          act.castout = dirty;
        end else begin
          act.rd = 1'b1;
        end
      end else begin
        act.nxt = ST_INV;
        case (cur)
          ST_INV: begin act.kind = BK_READ; act.beats = B1; end
          ST_EXC: act.retry = 1'b1;
          default: begin act.retry = 1'b1; act.kind = BK_WKILL; act.beats = B4; end
        endcase
      end
    end else if (!attr_i && !attr_w) begin
      if (cur == ST_INV) begin
        act.kind    = BK_RWITM;
        act.beats   = B4;
        act.castout = dirty;
      end else begin
        act.wr  = 1'b1;
        act.nxt = ST_MOD;
      end
    end else if (!attr_i) begin
      case (cur)
        ST_INV: begin act.kind = BK_WFLSH; act.beats = B1; end
        ST_EXC: begin act.wr = 1'b1; act.kind = BK_WFLSH; act.beats = B1; end
        default: begin act.retry = 1'b1; act.kind = BK_WKILL; act.beats = B4; end
      endcase
    end else begin
      act.nxt = ST_INV;
      case (cur)
        ST_INV: begin act.kind = BK_WFLSH; act.beats = B1; end
        ST_EXC: act.retry = 1'b1;
        default: begin act.retry = 1'b1; act.kind = BK_WKILL; act.beats = B4; end
      endcase
    end
  end

endmodule

// File: rtl/mei_coh_ctrl.sv
module mei_coh_ctrl
  import mei_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic             req_rsv,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_w,
  input  logic             req_i,
  input  logic             req_m,
  input  logic             victim_dirty,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_rwitm,
  output logic             rsp_valid,
  output logic [1:0]       rsp_state,
  output logic             cache_rd,
  output logic             cache_wr,
  output logic             retry,
  output logic             bus_valid,
  output logic [2:0]       bus_kind,
  output logic [2:0]       bus_beats,
  output logic             bus_rsv,
  output logic             castout_valid
);

  line_state_e cur_state;
  action_t     act;
  logic        unused_attr_m;

  // the coherence attribute does not change any decision here
  assign unused_attr_m = req_m;

  mei_state_array #(.LINES(LINES)) i_array (
    .clk        (clk),
    .rst        (rst),
    .rd_idx     (req_idx),
    .rd_state   (cur_state),
    .wr_en      (req_valid),
    .wr_idx     (req_idx),
    .wr_state   (act.nxt),
    .fill_en    (fill_valid),
    .fill_idx   (fill_idx),
    .fill_state (fill_rwitm ? ST_MOD : ST_EXC)
  );

  mei_decide i_decide (
    .cur      (cur_state),
    .is_store (req_store),
    .attr_w   (req_w),
    .attr_i   (req_i),
    .dirty    (victim_dirty),
    .act      (act)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid     <= 1'b0;
      rsp_state     <= 2'd0;
      cache_rd      <= 1'b0;
      cache_wr      <= 1'b0;
      retry         <= 1'b0;
      bus_valid     <= 1'b0;
      bus_kind      <= 3'd0;
      bus_beats     <= 3'd0;
      bus_rsv       <= 1'b0;
      castout_valid <= 1'b0;
    end else begin
      rsp_valid     <= 1'b1;
      rsp_state     <= cur_state;
      cache_rd      <= act.rd;
      cache_wr      <= act.wr;
      retry         <= act.retry;
      bus_valid     <= (act.kind != BK_NONE);
      bus_kind      <= act.kind;
      bus_beats     <= act.beats;
      bus_rsv       <= req_rsv && (act.kind != BK_NONE);
      castout_valid <= act.castout;
    end
  end

  // R12
  retry_excl_chk: assert property (@(posedge clk) disable iff (rst)
    retry |-> (!cache_rd && !cache_wr));

  // R12
  castout_burst_chk: assert property (@(posedge clk) disable iff (rst)
    castout_valid |-> (bus_beats == 3'd4 &&
                       (bus_kind == 3'(BK_READ) || bus_kind == 3'(BK_RWITM))));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(bus_valid || retry || cache_rd || cache_wr || castout_valid));

  // R11
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !$past(rst)) |=> rsp_valid);

  // R9
  rsv_flag_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rsv |-> bus_valid);

  // R1
  state_code_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_state != 2'd3));

endmodule

// File: tb/test_mei_coh_ctrl.sv
module test_mei_coh_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int IDX_W = $clog2(LINES);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_store = 0, req_rsv = 0, req_w = 0, req_i = 0, req_m = 0;
  logic victim_dirty = 0, fill_valid = 0, fill_rwitm = 0;
  logic [IDX_W-1:0] req_idx = '0, fill_idx = '0;
  logic rsp_valid, cache_rd, cache_wr, retry, bus_valid, bus_rsv, castout_valid;
  logic [1:0] rsp_state;
  logic [2:0] bus_kind, bus_beats;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mei_coh_ctrl #(.LINES(LINES)) i_mei_coh_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_rsv(req_rsv), .req_idx(req_idx), .req_w(req_w), .req_i(req_i),
    .req_m(req_m), .victim_dirty(victim_dirty), .fill_valid(fill_valid),
    .fill_idx(fill_idx), .fill_rwitm(fill_rwitm), .rsp_valid(rsp_valid),
    .rsp_state(rsp_state), .cache_rd(cache_rd), .cache_wr(cache_wr),
    .retry(retry), .bus_valid(bus_valid), .bus_kind(bus_kind),
    .bus_beats(bus_beats), .bus_rsv(bus_rsv), .castout_valid(castout_valid)
  );

  // {store,w,i,init[1:0],dirty, rd,wr,retry,kind[2:0],beats[2:0],castout,next[1:0]}
  localparam logic [17:0] VEC [16] = '{
    {1'b0,1'b0,1'b0,2'd0,1'b0, 1'b0,1'b0,1'b0,3'd1,3'd4,1'b0,2'd0},
    {1'b0,1'b0,1'b0,2'd0,1'b1, 1'b0,1'b0,1'b0,3'd1,3'd4,1'b1,2'd0},
    {1'b0,1'b0,1'b0,2'd1,1'b1, 1'b1,1'b0,1'b0,3'd0,3'd0,1'b0,2'd1},
    {1'b0,1'b0,1'b0,2'd2,1'b0, 1'b1,1'b0,1'b0,3'd0,3'd0,1'b0,2'd2},
    {1'b0,1'b0,1'b1,2'd0,1'b1, 1'b0,1'b0,1'b0,3'd1,3'd1,1'b0,2'd0},
    {1'b0,1'b0,1'b1,2'd1,1'b0, 1'b0,1'b0,1'b1,3'd0,3'd0,1'b0,2'd0},
    {1'b0,1'b0,1'b1,2'd2,1'b0, 1'b0,1'b0,1'b1,3'd4,3'd4,1'b0,2'd0},
    {1'b1,1'b0,1'b0,2'd0,1'b1, 1'b0,1'b0,1'b0,3'd2,3'd4,1'b1,2'd0},
    {1'b1,1'b0,1'b0,2'd1,1'b0, 1'b0,1'b1,1'b0,3'd0,3'd0,1'b0,2'd2},
    {1'b1,1'b0,1'b0,2'd2,1'b0, 1'b0,1'b1,1'b0,3'd0,3'd0,1'b0,2'd2},
    {1'b1,1'b1,1'b0,2'd0,1'b0, 1'b0,1'b0,1'b0,3'd3,3'd1,1'b0,2'd0},
    {1'b1,1'b1,1'b0,2'd1,1'b0, 1'b0,1'b1,1'b0,3'd3,3'd1,1'b0,2'd1},
    {1'b1,1'b1,1'b0,2'd2,1'b0, 1'b0,1'b0,1'b1,3'd4,3'd4,1'b0,2'd2},
    {1'b1,1'b0,1'b1,2'd0,1'b1, 1'b0,1'b0,1'b0,3'd3,3'd1,1'b0,2'd0},
    {1'b1,1'b1,1'b1,2'd1,1'b0, 1'b0,1'b0,1'b1,3'd0,3'd0,1'b0,2'd0},
    {1'b1,1'b0,1'b1,2'd2,1'b0, 1'b0,1'b0,1'b1,3'd4,3'd4,1'b0,2'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic st, input logic rsv, input int idx,
                        input logic w, input logic i, input logic m, input logic d);
    @(negedge clk);
    req_valid = 1; req_store = st; req_rsv = rsv; req_idx = IDX_W'(idx);
    req_w = w; req_i = i; req_m = m; victim_dirty = d;
    @(negedge clk);
    req_valid = 0; req_store = 0; req_rsv = 0; req_w = 0; req_i = 0; req_m = 0;
    victim_dirty = 0;
  endtask

  task automatic do_fill(input int idx, input logic rw);
    @(negedge clk);
    fill_valid = 1; fill_idx = IDX_W'(idx); fill_rwitm = rw;
    @(negedge clk);
    fill_valid = 0;
  endtask

  // a cacheable load never changes the state, so it reads the state back
  task automatic probe(input string req, input int idx, input int exp);
    do_req(1'b0, 1'b0, idx, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(req, "probed state", int'(rsp_state), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 R11: reset state and idle outputs
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R11", "idle bus_valid", int'(bus_valid), 0);
    probe("R1", 5, 0);

    // table walk: R2..R7
    for (int k = 0; k < 16; k++) begin
      logic [17:0] v;
      string tag;
      v = VEC[k];
      tag = !v[17] ? (v[15] ? "R4" : (v[14:13] == 0 ? "R2" : "R3"))
                   : (v[15] ? "R7" : (v[16] ? "R6" : "R5"));
      if (v[14:13] != 0) do_fill(k, v[14:13] == 2);
      do_req(v[17], 1'b0, k, v[16], v[15], 1'b0, v[12]);
      chk(tag, "rsp_valid", int'(rsp_valid), 1);
      chk(tag, "found state", int'(rsp_state), int'(v[14:13]));
      chk(tag, "cache_rd", int'(cache_rd), int'(v[11]));
      chk(tag, "cache_wr", int'(cache_wr), int'(v[10]));
      chk(tag, "retry", int'(retry), int'(v[9]));
      chk(tag, "bus_kind", int'(bus_kind), int'(v[8:6]));
      chk(tag, "bus_valid", int'(bus_valid), int'(v[8:6] != 0));
      chk(tag, "bus_beats", int'(bus_beats), int'(v[5:3]));
      chk(tag, "castout", int'(castout_valid), int'(v[2]));
      probe(tag, k, int'(v[1:0]));
    end

    // R11: quiet cycle after a request
    @(negedge clk);
    chk("R11", "idle rsp_valid", int'(rsp_valid), 0);
    chk("R11", "idle retry", int'(retry), 0);

    // R8: fill kinds and collision precedence
    rst = 1; @(negedge clk); rst = 0;
    probe("R1", 7, 0);
    do_fill(3, 1'b0); probe("R8", 3, 1);
    do_fill(4, 1'b1); probe("R8", 4, 2);
    // line 4 is Modified; inhibited load moves it to Invalid, while a same-cycle fill wants Exclusive
    @(negedge clk);
    req_valid = 1; req_store = 0; req_idx = 4; req_i = 1;
    fill_valid = 1; fill_idx = 4; fill_rwitm = 0;
    @(negedge clk);
    req_valid = 0; req_i = 0; fill_valid = 0;
    chk("R8", "collision retry", int'(retry), 1);
    probe("R8", 4, 0);
    // a fill to another line in the same cycle still lands
    @(negedge clk);
    req_valid = 1; req_store = 1; req_idx = 9; req_w = 1;
    fill_valid = 1; fill_idx = 10; fill_rwitm = 1;
    @(negedge clk);
    req_valid = 0; req_store = 0; req_w = 0; fill_valid = 0;
    probe("R8", 10, 2);

    // R9: reservation flag only with a bus operation
    do_req(1'b1, 1'b1, 12, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9", "bus_rsv with write", int'(bus_rsv), 1);
    do_req(1'b0, 1'b1, 12, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "bus_rsv with read", int'(bus_rsv), 1);
    do_fill(13, 1'b0);
    do_req(1'b0, 1'b1, 13, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "bus_rsv on hit", int'(bus_rsv), 0);
    do_req(1'b0, 1'b0, 12, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9", "bus_rsv plain", int'(bus_rsv), 0);

    // R10: coherence attribute ignored
    do_fill(14, 1'b0);
    do_req(1'b1, 1'b0, 14, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R10", "cache_wr", int'(cache_wr), 1);
    chk("R10", "bus_kind", int'(bus_kind), 3);
    chk("R10", "bus_beats", int'(bus_beats), 1);
    probe("R10", 14, 1);
    do_req(1'b0, 1'b0, 15, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10", "load bus_kind", int'(bus_kind), 1);
    chk("R10", "load castout", int'(castout_valid), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule